// File: doc/BRIEF.md
# Sorted Ready Queue with Local Cell Decisions

This block holds the tasks that are ready to run, kept in ascending order of a sort key. The key is supplied by the surrounding scheduler. It may be a static priority level, a period for rate-monotonic ordering, or an absolute deadline for earliest-deadline-first ordering. The queue does not interpret the key; it only compares it. The entry with the smallest key is always at the head, where the task-selection logic can read it without searching.

The storage is a line of identical cells. Each cell holds one entry: a valid bit, a task ID and a key. On every operation, each cell looks only at its own comparator, the entry beside it and one flag passed along from its neighbour. From those it chooses to keep its entry, accept the new one, or take a neighbour's entry. Because of this, insert, pop and remove-by-ID each finish in a single clock, whatever the fill level.

Only one operation runs per cycle. If several requests arrive in the same cycle, the queue picks one and ignores the rest. Arbitration against the running task is left to the logic that reads the head.

Top module: `prio_ready_queue`

## Requirements
- R1: After reset, the queue is empty: head_valid is 0 and full is 0.
- R2: An accepted insert places the entry so that keys run in non-decreasing order from the head. The head always shows the smallest key held, and an accepted insert raises the occupancy by exactly one.
- R3: An inserted entry whose key equals keys already held is placed behind all of them. Entries with equal keys therefore leave the head in the order they were inserted.
- R4: A pop removes the head entry, and the next entry moves to the head. A pop on an empty queue changes nothing.
- R5: A remove request deletes only the entry nearest the head whose ID equals rem_id, and the entries behind it close the gap. If no entry matches, the contents are unchanged.
- R6: full is 1 exactly when all DEPTH cells hold entries. An insert while full is refused and leaves the contents unchanged.
- R7: When requests arrive together, pop is served first, then remove, then insert. The requests that lose are dropped.
- R8: The head outputs and full reflect a request on the clock edge that samples it, one cycle after the request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_id | input | RQ_ID_W | Task ID to insert |
| ins_key | input | RQ_KEY_W | Sort key to insert; a smaller value is more urgent |
| rem_valid | input | 1 | Remove-by-ID request |
| rem_id | input | RQ_ID_W | Task ID to remove |
| pop | input | 1 | Remove the head entry |
| head_valid | output | 1 | The queue holds at least one entry |
| head_id | output | RQ_ID_W | Task ID at the head |
| head_key | output | RQ_KEY_W | Key at the head |
| full | output | 1 | All cells are occupied |

## Verification
On every cycle, the assertions check three structural properties. Valid entries stay packed toward the head, and adjacent keys never fall out of order. The occupancy moves by the right amount after an insert, a pop or a remove, and a refused insert leaves the whole state frozen. What only the bench scenarios can show is whether the right entry moved. That covers tie order among equal keys, which duplicate ID a remove takes, how competing requests resolve, and the exact sequence of IDs drained from the head. Each of these is compared against an independent array model.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int unsigned RQ_ID_W  = 4;
    localparam int unsigned RQ_KEY_W = 8;

    typedef struct packed {
        logic                vld;
        logic [RQ_ID_W-1:0]  id;
        logic [RQ_KEY_W-1:0] key;
    } rq_entry_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INS  = 2'd1,
        OP_REM  = 2'd2,
        OP_POP  = 2'd3
    } rq_op_e;
endpackage

// File: rtl/rq_op_sel.sv
module rq_op_sel
    import rq_pkg::*;
(
    input  logic   pop,
    input  logic   rem_valid,
    input  logic   ins_valid,
    input  logic   full,
    output rq_op_e op
);
    // Fixed precedence: pop, then remove, then insert (insert only with a free cell)
    always_comb begin
        if (pop)                     op = OP_POP;
        else if (rem_valid)          op = OP_REM;
        else if (ins_valid && !full) op = OP_INS;
        else                         op = OP_NONE;
    end
endmodule

// File: rtl/rq_cell.sv
module rq_cell
    import rq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rq_op_e             op,
    input  rq_entry_t          new_ent,
    input  logic [RQ_ID_W-1:0] rem_id,
    input  rq_entry_t          prev_ent,
    input  rq_entry_t          next_ent,
    input  logic               prev_win,
    input  logic               prev_hit,
    output logic               win,
    output logic               hit,
    output rq_entry_t          ent
);
    rq_entry_t ent_d, ent_q;

    always_comb begin
        // New entry belongs ahead of this cell's entry (strict: ties stay behind)
        win   = !ent_q.vld || (new_ent.key < ent_q.key);
        // A matching entry exists at or ahead of this cell
        hit   = prev_hit || (ent_q.vld && (ent_q.id == rem_id));
        ent_d = ent_q;
        unique case (op)
            OP_INS: begin
                if (prev_win)  ent_d = prev_ent;
                else if (win)  ent_d = new_ent;
            end
            OP_REM: begin
                if (hit)       ent_d = next_ent;
            end
            OP_POP:            ent_d = next_ent;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ent = ent_q;
endmodule

// File: rtl/prio_ready_queue.sv
module prio_ready_queue
    import rq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  logic [RQ_ID_W-1:0]  ins_id,
    input  logic [RQ_KEY_W-1:0] ins_key,
    input  logic                rem_valid,
    input  logic [RQ_ID_W-1:0]  rem_id,
    input  logic                pop,
    output logic                head_valid,
    output logic [RQ_ID_W-1:0]  head_id,
    output logic [RQ_KEY_W-1:0] head_key,
    output logic                full
);
    localparam int unsigned KEY_FLAT_W = DEPTH * RQ_KEY_W;

    rq_op_e    op;
    rq_entry_t new_ent;
    rq_entry_t ent  [DEPTH];
    logic      win  [DEPTH];
    logic      hit  [DEPTH];
    logic [DEPTH-1:0]      vld_vec;
    logic [KEY_FLAT_W-1:0] key_flat;

    assign new_ent = '{vld: 1'b1, id: ins_id, key: ins_key};

    rq_op_sel u_sel (
        .pop       (pop),
        .rem_valid (rem_valid),
        .ins_valid (ins_valid),
        .full      (full),
        .op        (op)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        rq_entry_t prev_e, next_e;
        logic      prev_w, prev_h;

        if (g == 0) begin : g_first
            assign prev_e = '0;
            assign prev_w = 1'b0;
            assign prev_h = 1'b0;
        end else begin : g_mid
            assign prev_e = ent[g-1];
            assign prev_w = win[g-1];
            assign prev_h = hit[g-1];
        end

        if (g == DEPTH-1) begin : g_last
            assign next_e = '0;
        end else begin : g_inner
            assign next_e = ent[g+1];
        end

        rq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .new_ent  (new_ent),
            .rem_id   (rem_id),
            .prev_ent (prev_e),
            .next_ent (next_e),
            .prev_win (prev_w),
            .prev_hit (prev_h),
            .win      (win[g]),
            .hit      (hit[g]),
            .ent      (ent[g])
        );

        assign vld_vec[g]                     = ent[g].vld;
        assign key_flat[g*RQ_KEY_W +: RQ_KEY_W] = ent[g].key;
    end

    assign head_valid = ent[0].vld;
    assign head_id    = ent[0].id;
    assign head_key   = ent[0].key;
    assign full       = ent[DEPTH-1].vld;
endmodule

// File: rtl/rq_checker.sv
module rq_checker
    import rq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ins_valid,
    input logic                         rem_valid,
    input logic                         pop,
    input logic                         head_valid,
    input logic                         full,
    input logic [DEPTH-1:0]             vld_vec,
    input logic [DEPTH*RQ_KEY_W-1:0]    key_flat
);
    int cnt;
    always_comb cnt = $countones(vld_vec);

    for (genvar i = 0; i < DEPTH-1; i++) begin : g_ord
        AST_PACKED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            vld_vec[i+1] |-> (vld_vec[i] &&
                key_flat[i*RQ_KEY_W +: RQ_KEY_W] <= key_flat[(i+1)*RQ_KEY_W +: RQ_KEY_W])); // R2
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (cnt == 0)); // R1

    AST_INS_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !pop && !rem_valid && !full) |=> (cnt == $past(cnt) + 1)); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_valid) |=> (cnt == $past(cnt) - 1)); // R4

    AST_POP_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !head_valid) |=> !head_valid); // R4

    AST_REM_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_valid && !pop) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1)); // R5

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !pop && !rem_valid && full) |=> ($stable(vld_vec) && $stable(key_flat))); // R6

    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        full == (cnt == DEPTH)); // R6
endmodule

bind prio_ready_queue rq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .rem_valid  (rem_valid),
    .pop        (pop),
    .head_valid (head_valid),
    .full       (full),
    .vld_vec    (vld_vec),
    .key_flat   (key_flat)
);

// File: tb/sim_prio_ready_queue.sv
module sim_prio_ready_queue;
    import rq_pkg::*;
    localparam int D = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n;
    logic                ins_valid, rem_valid, pop;
    logic [RQ_ID_W-1:0]  ins_id, rem_id;
    logic [RQ_KEY_W-1:0] ins_key;
    logic                head_valid, full;
    logic [RQ_ID_W-1:0]  head_id;
    logic [RQ_KEY_W-1:0] head_key;

    prio_ready_queue #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_id(ins_id),
        .ins_key(ins_key), .rem_valid(rem_valid), .rem_id(rem_id), .pop(pop),
        .head_valid(head_valid), .head_id(head_id), .head_key(head_key), .full(full)
    );

    int n_chk = 0;
    int n_err = 0;
    int m_id [D];
    int m_key[D];
    int m_cnt = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_head(string req);
        chk({req, " head_valid"}, int'(head_valid), int'(m_cnt > 0));
        if (m_cnt > 0) begin
            chk({req, " head_id"},  int'(head_id),  m_id[0]);
            chk({req, " head_key"}, int'(head_key), m_key[0]);
        end
        chk({req, " full"}, int'(full), int'(m_cnt == D));
    endtask

    task automatic m_shift_out(int idx);
        for (int k = idx; k < m_cnt - 1; k++) begin
            m_id[k]  = m_id[k+1];
            m_key[k] = m_key[k+1];
        end
        m_cnt--;
    endtask

    // Reference: R7 precedence, R2/R3 stable sorted insert, R5 first-match remove
    task automatic m_apply(bit p, bit r, int rid, bit i, int iid, int ikey);
        if (p) begin
            if (m_cnt > 0) m_shift_out(0);
        end else if (r) begin
            int f = -1;
            for (int k = 0; k < m_cnt; k++) if (f < 0 && m_id[k] == rid) f = k;
            if (f >= 0) m_shift_out(f);
        end else if (i && m_cnt < D) begin
            int pos = m_cnt;
            for (int k = m_cnt - 1; k >= 0; k--) if (ikey < m_key[k]) pos = k;
            for (int k = m_cnt; k > pos; k--) begin
                m_id[k]  = m_id[k-1];
                m_key[k] = m_key[k-1];
            end
            m_id[pos]  = iid;
            m_key[pos] = ikey;
            m_cnt++;
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (R8: one-cycle latency)
    task automatic step(bit p, bit r, int rid, bit i, int iid, int ikey, string req);
        pop = p; rem_valid = r; rem_id = rid[RQ_ID_W-1:0];
        ins_valid = i; ins_id = iid[RQ_ID_W-1:0]; ins_key = ikey[RQ_KEY_W-1:0];
        @(negedge clk);
        pop = 1'b0; rem_valid = 1'b0; ins_valid = 1'b0;
        m_apply(p, r, rid, i, iid, ikey);
        cmp_head(req);
    endtask

    task automatic ins(int iid, int ikey, string req);
        step(0, 0, 0, 1, iid, ikey, req);
    endtask

    task automatic drain(string req);
        while (m_cnt > 0) step(1, 0, 0, 0, 0, 0, req);
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pop = 1'b0; rem_valid = 1'b0; ins_valid = 1'b0;
        rem_id = '0; ins_id = '0; ins_key = '0;
        repeat (3) @(negedge clk);
        cmp_head("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_head("R1 after reset");

        // R4: pop on empty queue
        step(1, 0, 0, 0, 0, 0, "R4 pop empty");

        // R2: out-of-order keys, head tracks minimum, drain yields sorted order
        ins(5, 40, "R2 ins"); ins(6, 10, "R2 ins"); ins(7, 90, "R2 ins");
        ins(8, 25, "R2 ins"); ins(9, 5, "R2 ins");
        drain("R4 R2 drain order");

        // R3: equal keys leave in insertion order
        ins(3, 5, "R3 tie"); ins(1, 5, "R3 tie"); ins(2, 7, "R3 tie");
        ins(0, 5, "R3 tie"); ins(4, 2, "R3 tie");
        drain("R3 tie drain");

        // R5: remove middle, absent, head, duplicate ID (first match only)
        ins(1, 10, "R5 setup"); ins(2, 20, "R5 setup"); ins(3, 30, "R5 setup");
        ins(2, 40, "R5 setup"); ins(4, 50, "R5 setup");
        step(0, 1, 3, 0, 0, 0, "R5 remove middle");
        step(0, 1, 9, 0, 0, 0, "R5 remove absent");
        step(0, 1, 2, 0, 0, 0, "R5 remove dup first");
        step(0, 1, 1, 0, 0, 0, "R5 remove head");
        drain("R5 drain after remove");

        // R6: fill to capacity, then refused insert of most urgent key
        for (int k = 0; k < D; k++) ins(k, 200 - k * 7, "R6 fill");
        step(0, 0, 0, 1, 15, 0, "R6 insert while full");
        step(0, 1, 3, 0, 0, 0, "R6 remove from full");
        ins(3, 1, "R6 insert after space");
        drain("R6 drain");

        // R7: simultaneous requests
        ins(1, 30, "R7 setup"); ins(2, 20, "R7 setup");
        step(1, 0, 0, 1, 5, 1, "R7 pop beats insert");
        step(1, 1, 1, 0, 0, 0, "R7 pop beats remove");
        ins(6, 9, "R7 setup");
        step(0, 1, 6, 1, 7, 3, "R7 remove beats insert");
        drain("R7 drain");

        // Sweep: pseudo-random mixed operations against the model
        for (int s = 0; s < 4000; s++) begin
            int unsigned a = rnd();
            int sel = int'(a % 10);
            int id  = int'((a >> 4) % 16);
            int key = int'((a >> 9) % 8);
            if (sel < 5)       step(0, 0, 0, 1, id, key, "R2 R3 sweep insert");
            else if (sel < 7)  step(1, 0, 0, 0, 0, 0, "R4 sweep pop");
            else if (sel < 9)  step(0, 1, id, 0, 0, 0, "R5 sweep remove");
            else               step(a[20], a[21], id, 1, id, key, "R7 sweep mixed");
        end
        drain("R4 sweep drain");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule